// File: doc/BRIEF.md
# Five-Port Mesh Router Node

This block is one node of a two-dimensional mesh network. It has five 16-bit input ports (local, east, west, north, south) and five 16-bit output ports with the same names. Every input word is registered on each clock edge. A one-hot grant vector then picks one of the five registered words. The picked word is rebuilt into the node's packet layout, and its destination coordinates are compared with the node's own position, fixed by parameters. The rebuilt packet goes out on exactly one output register. All other outputs read zero.

A packet is one 16-bit word. The layout is: payload [15:8], reserved [7:5], destination X [4:3], destination Y [2:1] and a request flag [0]. Routing is dimension-ordered. The X difference is settled first. Y is looked at only once X already matches. A packet whose X and Y both match the node's position leaves on the local port.

Timing: a word present on an input at clock edge k is captured at that edge. The grant applied during the following cycle selects among the captured words. The result appears on the outputs after edge k+1.

Top module: `mesh_router_node`

## Requirements
- R1: Each input word is captured in its own register at every rising clock edge. The output after edge k+1 is formed from the words captured at edge k and the grant present before edge k+1.
- R2: The grant encoding is as follows. 5'b00001 selects local, 5'b00010 east, 5'b00100 west, 5'b01000 north and 5'b10000 south. Words on the ports that are not selected have no effect on any output.
- R3: A forwarded packet keeps payload [15:8], destination X [4:3], destination Y [2:1] and request [0] of the selected word. Its reserved bits [7:5] are driven to zero.
- R4: When destination X equals NODE_X and destination Y equals NODE_Y, the packet leaves on the local output.
- R5: When destination X is greater than NODE_X, the packet leaves east. When it is smaller, the packet leaves west. This holds whatever the Y value is.
- R6: When destination X equals NODE_X, a destination Y greater than NODE_Y sends the packet south, and a smaller one sends it north.
- R7: In every cycle at most one output is non-zero. Every output other than the routed one is zero.
- R8: When the grant is all zeros or has more than one bit set, all five outputs are zero in the next cycle.
- R9: When the selected word has request bit [0] clear, all five outputs are zero in the next cycle.
- R10: An active-low synchronous reset clears the input and output registers, so all outputs read zero after a clock edge with rst_n low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| local_in | input | 16 | Word from the attached endpoint |
| east_in | input | 16 | Word from the east neighbour |
| west_in | input | 16 | Word from the west neighbour |
| north_in | input | 16 | Word from the north neighbour |
| south_in | input | 16 | Word from the south neighbour |
| grant | input | 5 | One-hot input select |
| local_out | output | 16 | Packet to the attached endpoint |
| east_out | output | 16 | Packet toward east |
| west_out | output | 16 | Packet toward west |
| north_out | output | 16 | Packet toward north |
| south_out | output | 16 | Packet toward south |

## Verification
A wrong grant decode or a swapped input register shows up as the wrong payload on the routed port. This is visible in the single cycle after the grant is applied. A faulty coordinate comparison puts a correct packet on the wrong port, or on two ports at once, in that same output cycle. Because every output register is rewritten on every edge, a stale or leaked value is exposed one cycle later by a cycle in which nothing should be driven. The directed tests therefore follow each forwarded packet with cases that must give all-zero outputs.

// File: rtl/mesh_router_pkg.sv
package mesh_router_pkg;
  localparam int NUM_PORTS = 5;
  localparam int WORD_W    = 16;
  localparam int PAY_W     = 8;
  localparam int RSV_W     = 3;
  localparam int COORD_W   = 2;
  localparam int IDX_W     = $clog2(NUM_PORTS);

  typedef enum logic [IDX_W-1:0] {
    PORT_LOCAL = 3'd0,
    PORT_EAST  = 3'd1,
    PORT_WEST  = 3'd2,
    PORT_NORTH = 3'd3,
    PORT_SOUTH = 3'd4
  } port_e;

  typedef struct packed {
    logic [PAY_W-1:0]   payload;
    logic [RSV_W-1:0]   rsv;
    logic [COORD_W-1:0] dst_x;
    logic [COORD_W-1:0] dst_y;
    logic               req;
  } packet_t;

  // Dimension-ordered choice: X settles first, Y only when X matches.
  function automatic port_e xy_pick(input logic [COORD_W-1:0] dx,
                                    input logic [COORD_W-1:0] dy,
                                    input logic [COORD_W-1:0] cx,
                                    input logic [COORD_W-1:0] cy);
    port_e p;
    if (dx > cx)      p = PORT_EAST;
    else if (dx < cx) p = PORT_WEST;
    else if (dy > cy) p = PORT_SOUTH;
    else if (dy < cy) p = PORT_NORTH;
    else              p = PORT_LOCAL;
    return p;
  endfunction

  // Rebuild a word into the outgoing layout with the reserved field cleared.
  function automatic packet_t reframe(input packet_t p);
    packet_t o;
    o     = p;
    o.rsv = '0;
    return o;
  endfunction
endpackage

// File: rtl/router_in_regs.sv
module router_in_regs
  import mesh_router_pkg::*;
#(
  parameter int N = NUM_PORTS,
  parameter int W = WORD_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0][W-1:0] din,
  output logic [N-1:0][W-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_port
    always_ff @(posedge clk) begin
      if (!rst_n) q[i] <= '0;
      else        q[i] <= din[i];
    end

    // R1: each register holds the word seen at the previous edge
    p_capture_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (q[i] == $past(din[i])));
  end
endmodule

// File: rtl/router_select.sv
module router_select
  import mesh_router_pkg::*;
#(
  parameter int N = NUM_PORTS,
  parameter int W = WORD_W
) (
  input  logic [N-1:0][W-1:0] held,
  input  logic [N-1:0]        grant,
  output packet_t             pick_pkt,
  output logic                pick_ok,
  output logic                grant_ok
);
  logic [W-1:0] mux_word;

  assign grant_ok = $onehot(grant);

  always_comb begin
    mux_word = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) mux_word = mux_word | held[i];
    end
  end

  assign pick_pkt = reframe(packet_t'(mux_word));
  assign pick_ok  = grant_ok && pick_pkt.req;

  // R3: the reserved field never leaves the selector set
  always_comb begin
    a_rsv_clear_r3 : assert (pick_pkt.rsv == '0);
  end
endmodule

// File: rtl/router_route.sv
module router_route
  import mesh_router_pkg::*;
#(
  parameter int N = NUM_PORTS,
  parameter int W = WORD_W,
  parameter logic [COORD_W-1:0] NODE_X = 2'd1,
  parameter logic [COORD_W-1:0] NODE_Y = 2'd1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  packet_t             pick_pkt,
  input  logic                pick_ok,
  output logic [N-1:0][W-1:0] out_q
);
  port_e                dir;
  logic [N-1:0][W-1:0]  out_d;
  logic [N-1:0]         busy;
  logic                 home_hit;

  assign dir      = xy_pick(pick_pkt.dst_x, pick_pkt.dst_y, NODE_X, NODE_Y);
  assign home_hit = pick_ok && (pick_pkt.dst_x == NODE_X) && (pick_pkt.dst_y == NODE_Y);

  always_comb begin
    for (int i = 0; i < N; i++) begin
      out_d[i] = (pick_ok && (dir == port_e'(IDX_W'(i)))) ? W'(pick_pkt) : '0;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_out
    always_ff @(posedge clk) begin
      if (!rst_n) out_q[i] <= '0;
      else        out_q[i] <= out_d[i];
    end
    assign busy[i] = |out_q[i];
  end

  // R7: never more than one port carries a packet
  p_one_port_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(busy));
  // R9: nothing forwarded when the selection is not a live request
  p_drop_idle_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    !pick_ok |=> (busy == '0));
  // R4: a packet addressed to this node reaches the local port
  p_local_hit_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    home_hit |=> busy[int'(PORT_LOCAL)]);
  // R10: reset leaves every output clear
  p_reset_clear_r10 : assert property (@(posedge clk)
    !rst_n |=> (busy == '0));
endmodule

// File: rtl/mesh_router_node.sv
module mesh_router_node
  import mesh_router_pkg::*;
#(
  parameter logic [COORD_W-1:0] NODE_X = 2'd1,
  parameter logic [COORD_W-1:0] NODE_Y = 2'd1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [WORD_W-1:0]    local_in,
  input  logic [WORD_W-1:0]    east_in,
  input  logic [WORD_W-1:0]    west_in,
  input  logic [WORD_W-1:0]    north_in,
  input  logic [WORD_W-1:0]    south_in,
  input  logic [NUM_PORTS-1:0] grant,
  output logic [WORD_W-1:0]    local_out,
  output logic [WORD_W-1:0]    east_out,
  output logic [WORD_W-1:0]    west_out,
  output logic [WORD_W-1:0]    north_out,
  output logic [WORD_W-1:0]    south_out
);
  logic [NUM_PORTS-1:0][WORD_W-1:0] in_vec;
  logic [NUM_PORTS-1:0][WORD_W-1:0] held;
  logic [NUM_PORTS-1:0][WORD_W-1:0] out_vec;
  packet_t                          pick_pkt;
  logic                             pick_ok;
  logic                             grant_ok;

  assign in_vec[int'(PORT_LOCAL)] = local_in;
  assign in_vec[int'(PORT_EAST)]  = east_in;
  assign in_vec[int'(PORT_WEST)]  = west_in;
  assign in_vec[int'(PORT_NORTH)] = north_in;
  assign in_vec[int'(PORT_SOUTH)] = south_in;

  router_in_regs #(.N(NUM_PORTS), .W(WORD_W)) u_in (
    .clk(clk), .rst_n(rst_n), .din(in_vec), .q(held));

  router_select #(.N(NUM_PORTS), .W(WORD_W)) u_sel (
    .held(held), .grant(grant), .pick_pkt(pick_pkt),
    .pick_ok(pick_ok), .grant_ok(grant_ok));

  router_route #(.N(NUM_PORTS), .W(WORD_W), .NODE_X(NODE_X), .NODE_Y(NODE_Y)) u_route (
    .clk(clk), .rst_n(rst_n), .pick_pkt(pick_pkt), .pick_ok(pick_ok), .out_q(out_vec));

  assign local_out = out_vec[int'(PORT_LOCAL)];
  assign east_out  = out_vec[int'(PORT_EAST)];
  assign west_out  = out_vec[int'(PORT_WEST)];
  assign north_out = out_vec[int'(PORT_NORTH)];
  assign south_out = out_vec[int'(PORT_SOUTH)];

  // R8: a grant that is not one-hot yields silent outputs
  p_bad_grant_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    !grant_ok |=> ((local_out | east_out | west_out | north_out | south_out) == '0));
endmodule

// File: tb/mesh_router_node_test.sv
module mesh_router_node_test;
  localparam logic [1:0] CX = 2'd1;
  localparam logic [1:0] CY = 2'd2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] din [5];
  logic [4:0]  grant = '0;
  logic [15:0] dout [5];
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  mesh_router_node #(.NODE_X(CX), .NODE_Y(CY)) uut (
    .clk(clk), .rst_n(rst_n),
    .local_in(din[0]), .east_in(din[1]), .west_in(din[2]),
    .north_in(din[3]), .south_in(din[4]), .grant(grant),
    .local_out(dout[0]), .east_out(dout[1]), .west_out(dout[2]),
    .north_out(dout[3]), .south_out(dout[4]));

  function automatic logic [15:0] mk(input logic [7:0] pay, input logic [1:0] dx,
                                     input logic [1:0] dy, input logic rq);
    return {pay, 3'b111, dx, dy, rq};
  endfunction

  task automatic check_all(input logic [15:0] exp [5], input string tag);
    for (int p = 0; p < 5; p++) begin
      checks++;
      if (dout[p] !== exp[p]) begin
        errors++;
        $display("FAIL %s port%0d actual=%h expected=%h", tag, p, dout[p], exp[p]);
      end
    end
  endtask

  // Expected result built from the requirements only.
  task automatic expect_of(input logic [15:0] w [5], input logic [4:0] g,
                           output logic [15:0] exp [5]);
    logic [15:0] word;
    int src, dst;
    for (int p = 0; p < 5; p++) exp[p] = '0;
    case (g)
      5'b00001: src = 0;
      5'b00010: src = 1;
      5'b00100: src = 2;
      5'b01000: src = 3;
      5'b10000: src = 4;
      default:  src = -1;
    endcase
    if (src >= 0) begin
      word = w[src];
      if (word[0]) begin
        if (word[4:3] > CX)      dst = 1;
        else if (word[4:3] < CX) dst = 2;
        else if (word[2:1] > CY) dst = 4;
        else if (word[2:1] < CY) dst = 3;
        else                     dst = 0;
        exp[dst] = {word[15:8], 3'b000, word[4:0]};
      end
    end
  endtask

  task automatic run_case(input logic [15:0] w [5], input logic [4:0] g, input string tag);
    logic [15:0] exp [5];
    @(negedge clk);
    for (int p = 0; p < 5; p++) din[p] = w[p];
    grant = g;
    @(negedge clk);
    @(negedge clk);
    expect_of(w, g, exp);
    check_all(exp, tag);
  endtask

  task automatic t_reset();
    logic [15:0] z [5];
    for (int p = 0; p < 5; p++) z[p] = '0;
    check_all(z, "R10 reset");
  endtask

  task automatic t_grant_map();
    logic [15:0] w [5];
    for (int p = 0; p < 5; p++) w[p] = mk(8'h10 + 8'(p), 2'(p % 4), 2'((p + 1) % 4), 1'b1);
    for (int s = 0; s < 5; s++) run_case(w, 5'(1 << s), "R2 grant map R1");
  endtask

  task automatic t_local();
    logic [15:0] w [5];
    for (int p = 0; p < 5; p++) w[p] = 16'hffff;
    w[3] = mk(8'hA5, CX, CY, 1'b1);
    run_case(w, 5'b01000, "R4 local R3");
  endtask

  task automatic t_xroute();
    logic [15:0] w [5];
    for (int p = 0; p < 5; p++) w[p] = '0;
    w[0] = mk(8'h3C, 2'd3, 2'd0, 1'b1);
    run_case(w, 5'b00001, "R5 east");
    w[0] = mk(8'hC3, 2'd0, 2'd3, 1'b1);
    run_case(w, 5'b00001, "R5 west");
    w[2] = mk(8'h77, 2'd2, 2'd2, 1'b1);
    run_case(w, 5'b00100, "R5 east y-equal");
  endtask

  task automatic t_yroute();
    logic [15:0] w [5];
    for (int p = 0; p < 5; p++) w[p] = '0;
    w[4] = mk(8'h5A, CX, 2'd3, 1'b1);
    run_case(w, 5'b10000, "R6 south");
    w[4] = mk(8'h81, CX, 2'd0, 1'b1);
    run_case(w, 5'b10000, "R6 north R7");
  endtask

  task automatic t_bad_grant();
    logic [15:0] w [5];
    for (int p = 0; p < 5; p++) w[p] = mk(8'hEE, 2'd0, 2'd0, 1'b1);
    run_case(w, 5'b00000, "R8 zero grant");
    run_case(w, 5'b00110, "R8 two-hot grant");
    run_case(w, 5'b11111, "R8 all-hot grant");
  endtask

  task automatic t_no_req();
    logic [15:0] w [5];
    for (int p = 0; p < 5; p++) w[p] = mk(8'h99, 2'd3, 2'd3, 1'b1);
    w[1] = mk(8'h99, 2'd3, 2'd3, 1'b0);
    run_case(w, 5'b00010, "R9 request clear");
  endtask

  task automatic t_mid_reset();
    logic [15:0] w [5];
    logic [15:0] z [5];
    for (int p = 0; p < 5; p++) begin w[p] = mk(8'h42, 2'd3, 2'd1, 1'b1); z[p] = '0; end
    run_case(w, 5'b00001, "R1 before reset");
    rst_n = 1'b0;
    @(negedge clk);
    check_all(z, "R10 mid reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_all(z, "R10 input regs cleared");
  endtask

  initial begin
    for (int p = 0; p < 5; p++) din[p] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_grant_map();
    t_local();
    t_xroute();
    t_yroute();
    t_bad_grant();
    t_no_req();
    t_mid_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule